// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

The block gathers two kinds of per-channel event (descriptor finished, channel fault) from a set of DMA channels and turns them into four independent interrupt lines. Every channel keeps a separate copy of its event status and its enable mask for each of the four lines, so different software agents can each own one line and acknowledge events without disturbing the others. An event sets the status bit in all four copies at once. Software clears status bits by writing ones.

For each line, the masked channel status is folded into two summary words. The transmit word collects the even-numbered channels and the receive word collects the odd-numbered ones, with bit i standing for channel 2i or 2i+1 respectively. A third word per line holds block-wide events. A line is raised while any bit of its transmit, receive or block-wide word is set. Software reaches the block through a single-cycle register port: the write is taken on the clock edge, and the read data is combinational from the address.

Top module: `dma_irq_fold`

## Requirements
- R1: After reset all status bits, mask bits and block-wide words are zero, every summary word reads zero and `irq_o` is zero.
- R2: A pulse on `ch_done_i[c]` sets status bit 0 of channel c, and a pulse on `ch_err_i[c]` sets status bit 6, in the copies of all four lines. The change is visible after the clock edge that samples the pulse.
- R3: Writing a status register clears each of its bits 0 and 6 that is written as 1. Bits written as 0 are unchanged, and the other three lines' copies are unchanged.
- R4: A mask register stores bits 0 (done enable) and 6 (fault enable) of the written word. It reads back only those bits, with every other bit read as zero.
- R5: For line o, bit i of the transmit word is set when channel 2i has a status bit set in line o's copy whose mask bit in line o is also set. Bit i of the receive word is formed the same way from channel 2i+1.
- R6: A pulse on `glob_evt_i` ORs its bits into the block-wide word of all four lines. Writing 0xFFFFFFFF to one line's block-wide word clears that word only. Any other written value leaves it unchanged.
- R7: `irq_o[o]` is high exactly when line o's transmit, receive or block-wide word is nonzero.
- R8: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set. This holds for both channel status and block-wide words.
- R9: Clearing a mask bit removes that cause from the summary words and the interrupt line, while the status bit stays set.
- R10: Register word addresses with the default 10-bit address and four lines use o for the line index:
  - Transmit word: o.
  - Receive word: 4+o.
  - Block-wide word: 8+o.
  - Status of channel c: 512+8c+o.
  - Mask of channel c: 516+8c+o.
  
  Any other address reads 0 and ignores writes, and this includes channel numbers at or above `NUM_CH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_done_i | input | NUM_CH | Per-channel descriptor-finished event pulses |
| ch_err_i | input | NUM_CH | Per-channel fault event pulses |
| glob_evt_i | input | GLOB_W | Block-wide event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | NUM_OUT | Interrupt lines, one per line index |

## Verification
The bench builds the block with eight channels, four lines and an 8-bit block-wide word. This small size allows a full sweep of every channel, every line and both causes. Each step enables one cause on one line and fires the matching event. The bench then confirms that all four status copies are set, that exactly one summary bit and one interrupt line respond, that masking withdraws them, and that per-line clears are independent. Expected summary words and line vectors come from the channel parity and index arithmetic. The bench also reaches the same-cycle set-versus-clear races, the all-ones-only clear of the block-wide word, and addresses beyond the last channel.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned DONE_BIT = 0;
    localparam int unsigned ERR_BIT  = 6;

    typedef enum logic [1:0] {
        K_TX   = 2'd0,
        K_RX   = 2'd1,
        K_GLOB = 2'd2,
        K_NONE = 2'd3
    } sum_kind_e;
endpackage

// File: rtl/irqf_chan_regs.sv
module irqf_chan_regs #(
    parameter int unsigned NOUT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic            err_i,
    input  logic            stat_we_i,
    input  logic            mask_we_i,
    input  logic [NOUT-1:0] wsel_i,
    input  logic            wd_done_i,
    input  logic            wd_err_i,
    output logic [NOUT-1:0] stat_done_o,
    output logic [NOUT-1:0] stat_err_o,
    output logic [NOUT-1:0] mask_done_o,
    output logic [NOUT-1:0] mask_err_o,
    output logic [NOUT-1:0] pend_o
);
    typedef struct packed {
        logic [NOUT-1:0] sdone;
        logic [NOUT-1:0] serr;
        logic [NOUT-1:0] mdone;
        logic [NOUT-1:0] merr;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NOUT; o++) begin
            if (stat_we_i && wsel_i[o]) begin
                if (wd_done_i) st_d.sdone[o] = 1'b0;
                if (wd_err_i)  st_d.serr[o]  = 1'b0;
            end
            if (mask_we_i && wsel_i[o]) begin
                st_d.mdone[o] = wd_done_i;
                st_d.merr[o]  = wd_err_i;
            end
        end
        // events override a same-cycle clear
        if (done_i) st_d.sdone = '1;
        if (err_i)  st_d.serr  = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_done_o = st_q.sdone;
    assign stat_err_o  = st_q.serr;
    assign mask_done_o = st_q.mdone;
    assign mask_err_o  = st_q.merr;
    assign pend_o      = (st_q.sdone & st_q.mdone) | (st_q.serr & st_q.merr);

    for (genvar o = 0; o < NOUT; o++) begin : g_chk
        a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            done_i |=> st_q.sdone[o]);
        a_r8_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (err_i && stat_we_i && wsel_i[o] && wd_err_i) |=> st_q.serr[o]);
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we_i && wsel_i[o] && wd_done_i && !done_i) |=> !st_q.sdone[o]);
        a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(mask_we_i && wsel_i[o]) |=> $stable(st_q.mdone[o]) && $stable(st_q.merr[o]));
    end
endmodule

// File: rtl/irqf_glob.sv
module irqf_glob
    import irqf_pkg::*;
#(
    parameter int unsigned NOUT = 4,
    parameter int unsigned GW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GW-1:0]            evt_i,
    input  logic                     wr_i,
    input  logic [NOUT-1:0]          wsel_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [NOUT-1:0][GW-1:0]  word_o
);
    typedef struct packed {
        logic [NOUT-1:0][GW-1:0] w;
    } glob_st_t;

    glob_st_t st_d, st_q;
    logic     all_ones;

    assign all_ones = (wdata_i == {DATA_W{1'b1}});

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NOUT; o++) begin
            if (wr_i && wsel_i[o] && all_ones) st_d.w[o] = '0;
            st_d.w[o] = st_d.w[o] | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.w;

    for (genvar o = 0; o < NOUT; o++) begin : g_chk
        a_r6_clear_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && wsel_i[o] && all_ones && evt_i == '0) |=> st_q.w[o] == '0);
        a_r6_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && wsel_i[o] && all_ones) |=> (st_q.w[o] & $past(st_q.w[o])) == $past(st_q.w[o]));
        a_r8_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i != '0) |=> (st_q.w[o] & $past(evt_i)) == $past(evt_i));
    end
endmodule

// File: rtl/irqf_fold.sv
module irqf_fold #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned NOUT = 4,
    parameter int unsigned GW   = 8,
    localparam int unsigned HALF = NCH / 2
) (
    input  logic [NCH-1:0][NOUT-1:0]  pend_i,
    input  logic [NOUT-1:0][GW-1:0]   glob_i,
    output logic [NOUT-1:0][HALF-1:0] tx_o,
    output logic [NOUT-1:0][HALF-1:0] rx_o,
    output logic [NOUT-1:0]           irq_o
);
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        for (genvar i = 0; i < HALF; i++) begin : g_pair
            assign tx_o[o][i] = pend_i[2*i][o];
            assign rx_o[o][i] = pend_i[2*i+1][o];
        end
        assign irq_o[o] = (|tx_o[o]) | (|rx_o[o]) | (|glob_i[o]);
    end
endmodule

// File: rtl/dma_irq_fold.sv
module dma_irq_fold
    import irqf_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned GLOB_W  = 8,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  ch_done_i,
    input  logic [NUM_CH-1:0]  ch_err_i,
    input  logic [GLOB_W-1:0]  glob_evt_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [NUM_OUT-1:0] irq_o
);
    localparam int unsigned HALF   = NUM_CH / 2;
    localparam int unsigned OSEL_W = $clog2(NUM_OUT);
    localparam int unsigned CH_LSB = OSEL_W + 1;
    localparam int unsigned CH_W   = ADDR_W - 1 - CH_LSB;

    // decode
    logic              chan_reg;
    logic              is_mask;
    logic [OSEL_W-1:0] out_idx;
    logic [CH_W-1:0]   ch_idx;
    logic              glob_hi_zero;
    sum_kind_e         kind;
    logic [NUM_OUT-1:0] wsel;

    assign chan_reg     = reg_addr_i[ADDR_W-1];
    assign out_idx      = reg_addr_i[OSEL_W-1:0];
    assign is_mask      = reg_addr_i[OSEL_W];
    assign ch_idx       = reg_addr_i[ADDR_W-2:CH_LSB];
    assign kind         = sum_kind_e'(reg_addr_i[OSEL_W+1:OSEL_W]);
    assign glob_hi_zero = (reg_addr_i[ADDR_W-2:OSEL_W+2] == '0);
    assign wsel         = NUM_OUT'(1) << out_idx;

    logic [NUM_CH-1:0][NUM_OUT-1:0] sdone, serr, mdone, merr, pend;
    logic [NUM_OUT-1:0][GLOB_W-1:0] glob_w;
    logic [NUM_OUT-1:0][HALF-1:0]   tx_w, rx_w;
    logic                           glob_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = reg_we_i && chan_reg && (ch_idx == CH_W'(c));

        irqf_chan_regs #(.NOUT(NUM_OUT)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .done_i      (ch_done_i[c]),
            .err_i       (ch_err_i[c]),
            .stat_we_i   (hit && !is_mask),
            .mask_we_i   (hit && is_mask),
            .wsel_i      (wsel),
            .wd_done_i   (reg_wdata_i[DONE_BIT]),
            .wd_err_i    (reg_wdata_i[ERR_BIT]),
            .stat_done_o (sdone[c]),
            .stat_err_o  (serr[c]),
            .mask_done_o (mdone[c]),
            .mask_err_o  (merr[c]),
            .pend_o      (pend[c])
        );
    end

    assign glob_wr = reg_we_i && !chan_reg && glob_hi_zero && (kind == K_GLOB);

    irqf_glob #(.NOUT(NUM_OUT), .GW(GLOB_W)) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (glob_evt_i),
        .wr_i    (glob_wr),
        .wsel_i  (wsel),
        .wdata_i (reg_wdata_i),
        .word_o  (glob_w)
    );

    irqf_fold #(.NCH(NUM_CH), .NOUT(NUM_OUT), .GW(GLOB_W)) u_fold (
        .pend_i (pend),
        .glob_i (glob_w),
        .tx_o   (tx_w),
        .rx_o   (rx_w),
        .irq_o  (irq_o)
    );

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        if (chan_reg) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == CH_W'(c)) begin
                    if (is_mask) begin
                        reg_rdata_o[DONE_BIT] = mdone[c][out_idx];
                        reg_rdata_o[ERR_BIT]  = merr[c][out_idx];
                    end else begin
                        reg_rdata_o[DONE_BIT] = sdone[c][out_idx];
                        reg_rdata_o[ERR_BIT]  = serr[c][out_idx];
                    end
                end
            end
        end else if (glob_hi_zero) begin
            case (kind)
                K_TX:    reg_rdata_o[HALF-1:0]   = tx_w[out_idx];
                K_RX:    reg_rdata_o[HALF-1:0]   = rx_w[out_idx];
                K_GLOB:  reg_rdata_o[GLOB_W-1:0] = glob_w[out_idx];
                default: reg_rdata_o = '0;
            endcase
        end
    end

    a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ((pend != '0) || (glob_w != '0)));
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0));
endmodule

// File: tb/sim_dma_irq_fold.sv
module sim_dma_irq_fold;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ch_done = '0, ch_err = '0, glob_evt = '0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    dma_irq_fold #(.NUM_CH(8), .NUM_OUT(4), .GLOB_W(8), .ADDR_W(10)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_done_i(ch_done), .ch_err_i(ch_err),
        .glob_evt_i(glob_evt), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    function automatic int stat_a(int c, int o); return 512 + 8*c + o; endfunction
    function automatic int mask_a(int c, int o); return 516 + 8*c + o; endfunction
    function automatic int tx_a(int o); return o; endfunction
    function automatic int rx_a(int o); return 4 + o; endfunction
    function automatic int gl_a(int o); return 8 + o; endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); addr = 10'(a); wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = 10'(a); #1; v = rdata;
    endtask

    task automatic pulse(input logic [7:0] dn, input logic [7:0] er, input logic [7:0] gl);
        @(negedge clk); ch_done = dn; ch_err = er; glob_evt = gl;
        @(negedge clk); ch_done = '0; ch_err = '0; glob_evt = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {28'b0, irq}, 32'h0);
        for (int o = 0; o < 4; o++) begin
            rd(tx_a(o), v); chk("R1 tx", v, 0);
            rd(rx_a(o), v); chk("R1 rx", v, 0);
            rd(gl_a(o), v); chk("R1 glob", v, 0);
            rd(stat_a(7, o), v); chk("R1 stat", v, 0);
            rd(mask_a(0, o), v); chk("R1 mask", v, 0);
        end

        // R4 mask keeps only bits 0 and 6
        wr(mask_a(5, 3), 32'hFFFF_FFFF);
        rd(mask_a(5, 3), v); chk("R4 mask all ones", v, 32'h41);
        rd(mask_a(5, 2), v); chk("R4 other line mask", v, 32'h0);
        wr(mask_a(5, 3), 32'h0);
        rd(mask_a(5, 3), v); chk("R4 mask zero", v, 32'h0);

        // sweep: R2 R5 R7 R9 R3
        for (int o = 0; o < 4; o++) begin
            for (int c = 0; c < 8; c++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [31:0] bitv, etx, erx;
                    bitv = (k == 1) ? 32'h40 : 32'h1;
                    etx = (c % 2 == 0) ? (32'h1 << (c/2)) : 32'h0;
                    erx = (c % 2 == 1) ? (32'h1 << (c/2)) : 32'h0;
                    wr(mask_a(c, o), bitv);
                    rd(mask_a(c, o), v); chk("R4 mask readback", v, bitv);
                    if (k == 1) pulse('0, 8'(1 << c), '0);
                    else        pulse(8'(1 << c), '0, '0);
                    for (int o2 = 0; o2 < 4; o2++) begin
                        rd(stat_a(c, o2), v); chk("R2 status set in every line", v, bitv);
                    end
                    rd(tx_a(o), v); chk("R5 tx word", v, etx);
                    rd(rx_a(o), v); chk("R5 rx word", v, erx);
                    chk("R7 irq line", {28'b0, irq}, 32'h1 << o);
                    wr(mask_a(c, o), 32'h0);
                    chk("R9 masked irq", {28'b0, irq}, 32'h0);
                    rd(tx_a(o), v); chk("R9 masked tx", v, 32'h0);
                    rd(stat_a(c, o), v); chk("R9 status kept", v, bitv);
                    for (int o2 = 0; o2 < 4; o2++) begin
                        wr(stat_a(c, o2), 32'h41);
                        rd(stat_a(c, o2), v); chk("R3 w1c", v, 32'h0);
                    end
                end
            end
        end

        // R3 partial clears and per-line independence
        pulse(8'h08, 8'h08, '0);
        wr(stat_a(3, 1), 32'h1);
        rd(stat_a(3, 1), v); chk("R3 clear done only", v, 32'h40);
        rd(stat_a(3, 2), v); chk("R3 other line untouched", v, 32'h41);
        wr(stat_a(3, 2), 32'hFFFF_FFBE);
        rd(stat_a(3, 2), v); chk("R3 zero bits no effect", v, 32'h41);
        for (int o = 0; o < 4; o++) wr(stat_a(3, o), 32'h41);

        // R8 set beats clear on channel status
        wr(stat_a(2, 0), 32'h0);
        @(negedge clk); addr = 10'(stat_a(2, 0)); wdata = 32'h1; we = 1'b1; ch_done = 8'h04;
        @(negedge clk); we = 1'b0; ch_done = '0;
        rd(stat_a(2, 0), v); chk("R8 status set wins", v, 32'h1);
        for (int o = 0; o < 4; o++) wr(stat_a(2, o), 32'h41);

        // R5 several channels on one line
        for (int c = 0; c < 8; c++) wr(mask_a(c, 2), 32'h41);
        pulse(8'h55, 8'hAA, '0);
        rd(tx_a(2), v); chk("R5 all tx", v, 32'hF);
        rd(rx_a(2), v); chk("R5 all rx", v, 32'hF);
        rd(tx_a(1), v); chk("R5 unmasked line tx", v, 32'h0);
        chk("R7 only line 2", {28'b0, irq}, 32'h4);
        for (int c = 0; c < 8; c++) begin
            wr(mask_a(c, 2), 32'h0);
            for (int o = 0; o < 4; o++) wr(stat_a(c, o), 32'h41);
        end
        chk("R7 idle", {28'b0, irq}, 32'h0);

        // R6 block-wide words
        pulse('0, '0, 8'hA5);
        for (int o = 0; o < 4; o++) begin
            rd(gl_a(o), v); chk("R6 glob set", v, 32'hA5);
        end
        chk("R7 glob raises all", {28'b0, irq}, 32'hF);
        wr(gl_a(1), 32'hFFFF_0000);
        rd(gl_a(1), v); chk("R6 non all-ones ignored", v, 32'hA5);
        wr(gl_a(1), 32'hFFFF_FFFF);
        rd(gl_a(1), v); chk("R6 all-ones clears", v, 32'h0);
        rd(gl_a(3), v); chk("R6 other line kept", v, 32'hA5);
        chk("R7 line 1 dropped", {28'b0, irq}, 32'hD);
        @(negedge clk); addr = 10'(gl_a(0)); wdata = 32'hFFFF_FFFF; we = 1'b1; glob_evt = 8'h01;
        @(negedge clk); we = 1'b0; glob_evt = '0;
        rd(gl_a(0), v); chk("R8 glob set wins", v, 32'h01);
        for (int o = 0; o < 4; o++) wr(gl_a(o), 32'hFFFF_FFFF);
        chk("R6 all cleared", {28'b0, irq}, 32'h0);

        // R10 unmapped addresses
        wr(mask_a(8, 0), 32'h41);
        rd(mask_a(8, 0), v); chk("R10 channel 8 mask", v, 32'h0);
        rd(stat_a(9, 1), v); chk("R10 channel 9 status", v, 32'h0);
        pulse('0, '0, 8'h3C);
        rd(12, v); chk("R10 kind 3 reads zero", v, 32'h0);
        rd(16 + 2, v); chk("R10 high global region", v, 32'h0);
        wr(16 + 2, 32'hFFFF_FFFF);
        rd(gl_a(2), v); chk("R10 alias write ignored", v, 32'h3C);
        for (int c = 0; c < 8; c++) begin
            rd(mask_a(c, 0), v); chk("R10 no stray mask", v, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule